// File: doc/BRIEF.md
# Wiper Register Controller with Nonvolatile Initial Value

This block is the register and memory access controller behind the serial byte interface of a digitally controlled resistor. A protocol engine in front of it hands it decoded operations: an operation opens with a start address, carries any number of byte reads or byte writes, and is closed by an end strobe. The block holds the 7-bit volatile wiper code, which drives the resistor ladder and appears on an output. It also holds a volatile mode bit that selects whether the top address reaches the wiper alone or the wiper together with its stored initial value. Requests to the nonvolatile array are served from a 2048-byte array that is modelled inside the block.

Written bytes are gathered in a 16-byte page buffer. When the operation closes, the buffer is committed in one internal write cycle, and a busy output stays high for the whole cycle. After reset the wiper holds a mid-scale code. Once the nonvolatile read-ready input is seen, the wiper is loaded from the stored initial value. Until that load is complete, no request is accepted.

Top module: `wiper_nv_ctrl`

## Requirements
- R1: Synchronous reset sets wiper to 0x40, the mode bit to 0 and busy to 0. Every request is refused until the power-up load has finished.
- R2: The first cycle with nv_ready high after reset starts the load. Two clock edges later the wiper holds the low seven bits of the stored byte at 0x7FF.
- R3: A write to 0x7FF sets the wiper to data bits [6:0] on the next edge. When the mode bit is 0, {0, data[6:0]} is also staged for address 0x7FF. When the mode bit is 1, the stored copy is left unchanged.
- R4: A read of 0x7FF returns {0, wiper} when the mode bit is 1 and the stored byte at 0x7FF when it is 0. Bit 7 always reads 0.
- R5: A write to 0x7FE whose bits [6:0] are zero copies data bit 7 into the mode bit. A read of 0x7FE returns {mode, 7'b0}. A write to 0x7FE with any of bits [6:0] set leaves the mode bit unchanged and pulses ctrl_err for one cycle.
- R6: Writes to 0x7FC and 0x7FD are discarded, stage nothing, and reads of them return 0x00.
- R7: Writes to 0x000 through 0x7FB are staged in the page buffer. The array is updated during the commit that follows op_end, and later reads return the new bytes. Reads in between return the stored contents.
- R8: Each byte read or write advances the address offset bits [3:0] by one, modulo 16. Bits [10:4] stay fixed for the whole operation.
- R9: An op_end with at least one staged byte raises busy on the next edge and holds it for WR_CYCLES cycles. An op_end with nothing staged never raises busy.
- R10: A request is refused if it arrives while busy or loading, if it is an op_begin while an operation is open, or if it is an op_end or a byte access with no operation open. A refused request changes no state and pulses nack one cycle later.
- R11: An accepted byte_rd sets rd_valid high for one cycle on the next edge, with rd_data valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nv_ready | input | 1 | Nonvolatile array is readable; starts the power-up wiper load |
| op_begin | input | 1 | Opens an operation at op_addr |
| op_addr | input | 11 | Start address of the operation |
| op_end | input | 1 | Closes the operation and commits any staged bytes |
| byte_wr | input | 1 | Writes byte_wdata at the current address |
| byte_wdata | input | 8 | Write data byte |
| byte_rd | input | 1 | Reads the byte at the current address |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read response strobe |
| wiper | output | 7 | Wiper code, 0x00 at the low end and 0x7F at the high end |
| busy | output | 1 | Internal nonvolatile write cycle in progress |
| ctrl_err | output | 1 | Write to 0x7FE with nonzero low bits was rejected |
| nack | output | 1 | The previous cycle's request was refused |

## Verification
The bench builds the block with the default 11-bit address, 16-byte pages and 7-bit wiper. This keeps the special top page, with its general bytes, reserved bytes, mode byte and wiper byte, reachable through ordinary operations, including offset wrap from 0x7FF back to 0x7F0. WR_CYCLES is set to 20, just above the page size. The full commit sequence, refusals during busy, and the end of busy can then all be reached in a few dozen cycles per commit. A second reset partway through the run shows the wiper being reloaded from an initial value that the bench itself wrote earlier.

// File: rtl/wnv_pkg.sv
package wnv_pkg;

  typedef enum logic [1:0] {
    K_GEN = 2'd0,
    K_RSV = 2'd1,
    K_CTL = 2'd2,
    K_IVR = 2'd3
  } addr_kind_e;

  // Decode an address relative to the top of the address space.
  function automatic addr_kind_e classify(input logic [15:0] a, input logic [15:0] top);
    if (a == top)                                        return K_IVR;
    else if (a == top - 16'd1)                           return K_CTL;
    else if ((a == top - 16'd2) || (a == top - 16'd3))   return K_RSV;
    else                                                 return K_GEN;
  endfunction

endpackage

// File: rtl/wnv_store.sv
module wnv_store #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 64
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              rd_en,
  input  logic [ADDR_W-1:0]                 rd_addr,
  output logic [DATA_W-1:0]                 rd_q,
  input  logic                              stage_we,
  input  logic [$clog2(PAGE_BYTES)-1:0]     stage_idx,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] stage_page,
  input  logic [DATA_W-1:0]                 stage_data,
  input  logic                              commit,
  output logic                              busy
);
  localparam int DEPTH  = 2 ** ADDR_W;
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int CNT_W  = $clog2(WR_CYCLES + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] stg [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] dirty;
  logic [PAGE_W-1:0]     page_q;
  logic                  busy_q;
  logic [CNT_W-1:0]      cnt;
  logic [OFF_W-1:0]      cidx;
  logic                  cwr;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  assign cidx = cnt[OFF_W-1:0];
  assign cwr  = busy_q && (cnt < CNT_W'(PAGE_BYTES)) && dirty[cidx];
  assign busy = busy_q;

  // Array: one write port for the commit walk, one registered read port.
  always_ff @(posedge clk) begin
    if (cwr) mem[{page_q, cidx}] <= stg[cidx];
    if (rd_en) rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (stage_we) stg[stage_idx] <= stage_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dirty  <= '0;
      page_q <= '0;
      busy_q <= 1'b0;
      cnt    <= '0;
    end else begin
      if (stage_we) begin
        dirty[stage_idx] <= 1'b1;
        page_q           <= stage_page;
      end
      if (commit && (|dirty)) begin
        busy_q <= 1'b1;
        cnt    <= '0;
      end else if (busy_q) begin
        if (cnt == CNT_W'(WR_CYCLES - 1)) begin
          busy_q <= 1'b0;
          dirty  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R9: busy only starts after a commit request
  p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(commit));

  // R9: nothing is staged while a commit walk runs
  p_no_stage_busy_r9: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !stage_we);

endmodule

// File: rtl/wnv_ctrl.sv
module wnv_ctrl
  import wnv_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int WIPER_W    = 7,
  parameter int WIPER_RST  = 64
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              nv_ready,
  input  logic                              busy,
  input  logic                              op_begin,
  input  logic [ADDR_W-1:0]                 op_addr,
  input  logic                              op_end,
  input  logic                              byte_wr,
  input  logic [DATA_W-1:0]                 byte_wdata,
  input  logic                              byte_rd,
  input  logic [DATA_W-1:0]                 mem_q,
  output logic                              mem_re,
  output logic [ADDR_W-1:0]                 mem_raddr,
  output logic                              stage_we,
  output logic [$clog2(PAGE_BYTES)-1:0]     stage_idx,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] stage_page,
  output logic [DATA_W-1:0]                 stage_data,
  output logic                              commit,
  output logic [DATA_W-1:0]                 rd_data,
  output logic                              rd_valid,
  output logic [WIPER_W-1:0]                wiper,
  output logic                              ctrl_err,
  output logic                              nack
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam logic [ADDR_W-1:0] TOP = '1;

  logic               open_q, ld_pend, ld_stage, ov_q;
  logic [PAGE_W-1:0]  pg_q;
  logic [OFF_W-1:0]   off_q;
  logic [WIPER_W-1:0] wiper_q;
  logic               from_mem_q, rdv_q, err_q, nack_q;
  logic [DATA_W-1:0]  alt_q;
  logic               any_req, byte_req, refuse, take;
  logic [ADDR_W-1:0]  cur;
  addr_kind_e         kind;

  assign any_req  = op_begin | op_end | byte_wr | byte_rd;
  assign byte_req = byte_wr | byte_rd;
  assign refuse   = any_req && (busy || ld_pend || (op_begin && open_q) ||
                                ((op_end || byte_req) && !open_q));
  assign take     = any_req && !refuse;
  assign cur      = {pg_q, off_q};
  assign kind     = classify(16'(cur), 16'(TOP));

  assign stage_we   = take && byte_wr && ((kind == K_GEN) || ((kind == K_IVR) && !ov_q));
  assign stage_idx  = off_q;
  assign stage_page = pg_q;
  assign stage_data = (kind == K_IVR) ? DATA_W'(byte_wdata[WIPER_W-1:0]) : byte_wdata;
  assign commit     = take && op_end;
  assign mem_re     = (ld_pend && nv_ready && !ld_stage) || (take && byte_rd);
  assign mem_raddr  = ld_pend ? TOP : cur;

  assign rd_data  = from_mem_q ? mem_q : alt_q;
  assign rd_valid = rdv_q;
  assign wiper    = wiper_q;
  assign ctrl_err = err_q;
  assign nack     = nack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q     <= 1'b0;
      ld_pend    <= 1'b1;
      ld_stage   <= 1'b0;
      ov_q       <= 1'b0;
      wiper_q    <= WIPER_W'(WIPER_RST);
      pg_q       <= '0;
      off_q      <= '0;
      from_mem_q <= 1'b0;
      alt_q      <= '0;
      rdv_q      <= 1'b0;
      err_q      <= 1'b0;
      nack_q     <= 1'b0;
    end else begin
      rdv_q  <= take && byte_rd;
      err_q  <= 1'b0;
      nack_q <= refuse;
      // Power-up load: read request, then capture of the stored initial value.
      if (ld_pend) begin
        if (ld_stage) begin
          wiper_q  <= mem_q[WIPER_W-1:0];
          ld_pend  <= 1'b0;
          ld_stage <= 1'b0;
        end else if (nv_ready) begin
          ld_stage <= 1'b1;
        end
      end
      if (take) begin
        if (op_begin) begin
          open_q <= 1'b1;
          pg_q   <= op_addr[ADDR_W-1:OFF_W];
          off_q  <= op_addr[OFF_W-1:0];
        end
        if (op_end) open_q <= 1'b0;
        if (byte_req) off_q <= off_q + 1'b1;
        if (byte_wr) begin
          case (kind)
            K_CTL: begin
              if (|byte_wdata[DATA_W-2:0]) err_q <= 1'b1;
              else                          ov_q  <= byte_wdata[DATA_W-1];
            end
            K_IVR:   wiper_q <= byte_wdata[WIPER_W-1:0];
            default: ;
          endcase
        end
        if (byte_rd) begin
          from_mem_q <= (kind == K_GEN) || ((kind == K_IVR) && !ov_q);
          case (kind)
            K_CTL:   alt_q <= {ov_q, {(DATA_W-1){1'b0}}};
            K_IVR:   alt_q <= DATA_W'(wiper_q);
            default: alt_q <= '0;
          endcase
        end
      end
    end
  end

  // R1: leaving reset shows the mid-scale wiper and a cleared mode bit
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (wiper_q == WIPER_W'(WIPER_RST)) && !ov_q);

  // R10: a refused request leaves the mode bit alone
  p_nack_keeps_ov_r10: assert property (@(posedge clk) disable iff (rst)
    nack_q |-> $stable(ov_q));

  // R5: a rejected control write leaves the mode bit alone
  p_err_keeps_ov_r5: assert property (@(posedge clk) disable iff (rst)
    err_q |-> $stable(ov_q));

  // R11: a read response always follows a read request
  p_rdv_cause_r11: assert property (@(posedge clk) disable iff (rst)
    rdv_q |-> $past(byte_rd));

  // R10: no read completes while the array is busy
  p_busy_no_read_r10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !rdv_q);

endmodule

// File: rtl/wiper_nv_ctrl.sv
module wiper_nv_ctrl #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int WIPER_W    = 7,
  parameter int WIPER_RST  = 64,
  parameter int WR_CYCLES  = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               nv_ready,
  input  logic               op_begin,
  input  logic [ADDR_W-1:0]  op_addr,
  input  logic               op_end,
  input  logic               byte_wr,
  input  logic [DATA_W-1:0]  byte_wdata,
  input  logic               byte_rd,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid,
  output logic [WIPER_W-1:0] wiper,
  output logic               busy,
  output logic               ctrl_err,
  output logic               nack
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic              mem_re, stage_we, commit;
  logic [ADDR_W-1:0] mem_raddr;
  logic [DATA_W-1:0] mem_q, stage_data;
  logic [OFF_W-1:0]  stage_idx;
  logic [PAGE_W-1:0] stage_page;

  wnv_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES),
    .WIPER_W(WIPER_W), .WIPER_RST(WIPER_RST)
  ) u_ctrl (
    .clk(clk), .rst(rst), .nv_ready(nv_ready), .busy(busy),
    .op_begin(op_begin), .op_addr(op_addr), .op_end(op_end),
    .byte_wr(byte_wr), .byte_wdata(byte_wdata), .byte_rd(byte_rd),
    .mem_q(mem_q), .mem_re(mem_re), .mem_raddr(mem_raddr),
    .stage_we(stage_we), .stage_idx(stage_idx), .stage_page(stage_page),
    .stage_data(stage_data), .commit(commit),
    .rd_data(rd_data), .rd_valid(rd_valid), .wiper(wiper),
    .ctrl_err(ctrl_err), .nack(nack)
  );

  wnv_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)
  ) u_store (
    .clk(clk), .rst(rst), .rd_en(mem_re), .rd_addr(mem_raddr), .rd_q(mem_q),
    .stage_we(stage_we), .stage_idx(stage_idx), .stage_page(stage_page),
    .stage_data(stage_data), .commit(commit), .busy(busy)
  );

endmodule

// File: tb/wiper_nv_ctrl_tb.sv
`timescale 1ns/1ps
module wiper_nv_ctrl_tb;
  localparam int WR = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nv_ready = 1'b0;
  logic op_begin = 1'b0, op_end = 1'b0, byte_wr = 1'b0, byte_rd = 1'b0;
  logic [10:0] op_addr = '0;
  logic [7:0]  byte_wdata = '0;
  logic [7:0]  rd_data;
  logic        rd_valid, busy, ctrl_err, nack;
  logic [6:0]  wiper;

  always #2 clk = ~clk;

  wiper_nv_ctrl #(.WR_CYCLES(WR)) u_dut (
    .clk(clk), .rst(rst), .nv_ready(nv_ready), .op_begin(op_begin), .op_addr(op_addr),
    .op_end(op_end), .byte_wr(byte_wr), .byte_wdata(byte_wdata), .byte_rd(byte_rd),
    .rd_data(rd_data), .rd_valid(rd_valid), .wiper(wiper), .busy(busy),
    .ctrl_err(ctrl_err), .nack(nack)
  );

  // Behavioural reference state
  int m_mem [2048];
  int pend [int];
  int m_busy, m_wip, m_ptr;
  bit m_ldp, m_lds, m_ov, m_open;
  bit e_rv, e_err, e_nack;
  int e_rd;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, string what, int act, int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit ob = 0, input int oa = 0, input bit oe = 0,
                      input bit bw = 0, input int wd = 0, input bit br = 0);
    bit blk;
    int a;
    op_begin = ob; op_addr = oa[10:0]; op_end = oe;
    byte_wr = bw; byte_wdata = wd[7:0]; byte_rd = br;
    e_rv = 0; e_err = 0; e_nack = 0;
    if (rst) begin
      m_busy = 0; m_ldp = 1; m_lds = 0; m_ov = 0; m_wip = 64; m_open = 0; pend.delete();
    end else begin
      blk = (m_busy > 0) || m_ldp;
      if (m_busy > 0) m_busy--;
      if (m_ldp) begin
        if (m_lds) begin m_wip = m_mem[2047] & 127; m_ldp = 0; m_lds = 0; end
        else if (nv_ready) m_lds = 1;
      end
      if (ob | oe | bw | br) begin
        if (blk || (ob && m_open) || ((oe | bw | br) && !m_open)) e_nack = 1;
        else if (ob) begin m_open = 1; m_ptr = oa; end
        else if (oe) begin
          m_open = 0;
          if (pend.num() > 0) begin
            foreach (pend[k]) m_mem[k] = pend[k];
            pend.delete();
            m_busy = WR;
          end
        end else begin
          a = m_ptr;
          m_ptr = (a & ~15) | ((a + 1) & 15);
          if (bw) begin
            if (a <= 2043) pend[a] = wd;
            else if (a == 2046) begin
              if ((wd & 127) != 0) e_err = 1; else m_ov = wd[7];
            end else if (a == 2047) begin
              if (!m_ov) pend[a] = wd & 127;
              m_wip = wd & 127;
            end
          end else begin
            e_rv = 1;
            if (a <= 2043) e_rd = m_mem[a];
            else if (a == 2046) e_rd = m_ov ? 128 : 0;
            else if (a == 2047) e_rd = m_ov ? m_wip : m_mem[2047];
            else e_rd = 0;
          end
        end
      end
    end
    @(posedge clk);
    #1;
    checks++;
    chk(tag, "wiper", int'(wiper), m_wip);
    chk(tag, "busy", int'(busy), int'(m_busy > 0));
    chk(tag, "rd_valid", int'(rd_valid), int'(e_rv));
    chk(tag, "ctrl_err", int'(ctrl_err), int'(e_err));
    chk(tag, "nack", int'(nack), int'(e_nack));
    if (e_rv) chk(tag, "rd_data", int'(rd_data), e_rd);
    op_begin = 0; op_end = 0; byte_wr = 0; byte_rd = 0;
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask
  task automatic opb(string tag, int a); step(tag, 1, a); endtask
  task automatic ope(string tag);        step(tag, 0, 0, 1); endtask
  task automatic wrb(string tag, int d); step(tag, 0, 0, 0, 1, d); endtask
  task automatic rdb(string tag);        step(tag, 0, 0, 0, 0, 0, 1); endtask

  initial begin
    for (int i = 0; i < 2048; i++) m_mem[i] = 0;
    // R1: reset state and refusal while the load is pending
    rst = 1; idle("R1", 3);
    rst = 0; idle("R1", 2);
    opb("R1", 'h000);
    idle("R1", 1);
    // R2: power-up load of the (zero) stored value
    nv_ready = 1; idle("R2", 3);
    // R3: write the wiper with mode 0, stored copy follows
    opb("R3", 'h7FE); wrb("R5", 'h00); wrb("R3", 'hA5); ope("R9");
    rdb("R10"); opb("R10", 'h000);
    idle("R9", WR);
    // R4: read stored value with mode 0
    opb("R4", 'h7FF); rdb("R4"); ope("R9"); idle("R9", 2);
    // R5: mode 1, wiper-only write
    opb("R5", 'h7FE); wrb("R5", 'h80); wrb("R3", 'h9A); ope("R9"); idle("R9", 2);
    opb("R4", 'h7FF); rdb("R4"); ope("R4");
    opb("R5", 'h7FE); rdb("R5"); wrb("R5", 'h00); rdb("R4"); ope("R4");
    // R5: rejected control write
    opb("R5", 'h7FE); wrb("R5", 'h81); ope("R5");
    opb("R5", 'h7FE); rdb("R5"); wrb("R5", 'h7F); rdb("R5"); ope("R5");
    // R6: reserved bytes
    opb("R6", 'h7FC); wrb("R6", 'h11); wrb("R6", 'h22); ope("R6"); idle("R6", 2);
    opb("R6", 'h7FC); rdb("R6"); rdb("R6"); ope("R6");
    // R7 and R8: general bytes and page wrap
    opb("R8", 'h01E); wrb("R8", 'hA1); wrb("R8", 'hA2); wrb("R8", 'hA3);
    opb("R10", 'h020); ope("R7");
    idle("R7", WR + 1);
    opb("R7", 'h010); rdb("R7"); rdb("R7"); ope("R7");
    opb("R8", 'h01E); rdb("R8"); rdb("R8"); rdb("R8"); ope("R8");
    opb("R7", 'h000); wrb("R7", 'h5C); ope("R7"); idle("R7", WR + 1);
    opb("R7", 'h000); rdb("R11"); idle("R11", 1); rdb("R11"); ope("R7");
    // R8: wrap from the wiper byte to the page start
    opb("R8", 'h7FF); wrb("R3", 'h33); wrb("R8", 'h44); ope("R9"); idle("R9", WR + 1);
    opb("R8", 'h7F0); rdb("R8"); ope("R8");
    opb("R4", 'h7FF); rdb("R4"); ope("R4");
    // R10: requests with no open operation
    wrb("R10", 'h12); rdb("R10"); ope("R10"); idle("R10", 1);
    // R1 and R2: second reset reloads the written initial value
    rst = 1; idle("R1", 2);
    rst = 0; idle("R2", 4);
    opb("R2", 'h7FF); rdb("R2"); ope("R2");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog: actual hung, expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule